// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Register

This block carries a single word from a writer on one clock to a reader on an unrelated clock, beside a FIFO data path and not through it. On the write side, a write with the mailbox-select input high is captured in a one-deep mailbox register. A write with the select low is routed to the FIFO write interface. On the read side, the mailbox-select input chooses whether the read data bus shows the mailbox word or the FIFO output register. A read with the select low is passed on as a FIFO read strobe.

An active-low flag, registered on the write clock, shows that the mailbox holds a word the reader has not taken yet. While the flag is low, further mailbox writes are dropped. Two events cross between the domains, each as a toggle through a two-stage synchronizer: "word posted" goes to the read side and "word taken" comes back. The flag returns high once the acknowledge from the read side has reached the write side. A master reset and a partial reset, both asynchronous and active low, empty the mailbox. Only the master reset also clears the stored word.

Top module: `xdom_mailbox`

## Requirements
- R1: While master reset is low, and after it is released, the flag `mbFullN` is 1. With `rdMbSel` = 1, `rdData` reads all zeroes.
- R2: At a `wrClk` rising edge with `wrEn` = 1, `wrMbSel` = 1 and `mbFullN` = 1, `wrData` is stored as the mailbox word, and `mbFullN` is 0 after that same edge.
- R3: A mailbox write at an edge where `mbFullN` is 0 is ignored, and the stored word stays unchanged.
- R4: A `rdClk` rising edge with `rdEn` = 1 and `rdMbSel` = 1, while a posted word is visible on the read side, drives `mbFullN` back to 1 within 4 `wrClk` cycles.
- R5: `rdData` equals the mailbox word when `rdMbSel` = 1, and equals `fifoRdData` when `rdMbSel` = 0.
- R6: A write with `wrMbSel` = 0 raises `fifoWrEn` in that cycle with `fifoWrData` = `wrData`. It leaves the mailbox word and `mbFullN` unchanged.
- R7: A read with `rdMbSel` = 0 raises `fifoRdEn` and does not empty the mailbox, so `mbFullN` stays 0.
- R8: A partial reset pulse sets `mbFullN` to 1 and keeps the stored mailbox word.
- R9: A master reset pulse sets `mbFullN` to 1 and clears the stored word to zero.
- R10: A mailbox read while nothing is posted has no effect: a later mailbox write still keeps `mbFullN` at 0 until a real mailbox read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mstRstN | input | 1 | Master reset, asynchronous, active low |
| prtRstN | input | 1 | Partial reset, asynchronous, active low |
| wrEn | input | 1 | Write request |
| wrMbSel | input | 1 | 1: write to mailbox, 0: write to FIFO |
| wrData | input | 36 | Write data |
| fifoWrEn | output | 1 | Write strobe toward the FIFO |
| fifoWrData | output | 36 | Write data toward the FIFO |
| mbFullN | output | 1 | Low while the mailbox holds an unread word (wrClk domain) |
| rdEn | input | 1 | Read request |
| rdMbSel | input | 1 | 1: read the mailbox, 0: read the FIFO |
| fifoRdData | input | 36 | FIFO output register contents |
| fifoRdEn | output | 1 | Read strobe toward the FIFO |
| rdData | output | 36 | Read data bus |

## Verification
The case of interest is a new mailbox write that arrives in the same write-clock cycle as the returning acknowledge. A word is posted and then read. From the next write cycle on, a mailbox write is presented on every cycle, each time with fresh data, so that the attempts straddle the edge at which the flag rises. The bench notes which data word is presented in the first cycle whose flag value, sampled before the edge, is high. It then checks that exactly that word was stored, that the flag is low again, and that every earlier attempt was dropped.

// File: rtl/xdom_mailbox_pkg.sv
package xdom_mailbox_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // capture wrData into the mailbox (wrClk domain)
    logic showMbox;   // steer the mailbox word onto rdData
  } mbStrobes_t;
endpackage

// File: rtl/xdom_mbox_sync.sv
module xdom_mbox_sync #(
  parameter int Stages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [Stages-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[Stages-2:0], d};
  end

  assign q = chain[Stages-1];
endmodule

// File: rtl/xdom_mbox_ctrl.sv
module xdom_mbox_ctrl
  import xdom_mailbox_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrMbSel,
  input  logic       rdEn,
  input  logic       rdMbSel,
  output logic       fifoWrEn,
  output logic       fifoRdEn,
  output logic       mbFullN,
  output mbStrobes_t strobes
);
  // write domain
  logic holdFull;      // mailbox holds an unread word
  logic postTgl;       // flips on every accepted mailbox write
  logic ackSync;       // synchronized read-side toggle
  logic ackSeen;       // last acknowledge toggle consumed
  logic acceptWr;
  logic ackArrived;

  // read domain
  logic postSync;
  logic takeTgl;       // flips on every accepted mailbox read
  logic pending;
  logic acceptRd;

  assign acceptWr   = wrEn && wrMbSel && !holdFull;
  assign ackArrived = ackSync != ackSeen;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      postTgl  <= 1'b0;
      ackSeen  <= 1'b0;
    end else begin
      if (ackArrived) begin
        ackSeen  <= ackSync;
        holdFull <= 1'b0;
      end else if (acceptWr) begin
        postTgl  <= ~postTgl;
        holdFull <= 1'b1;
      end
    end
  end

  xdom_mbox_sync #(.Stages(SyncStages)) ackSync_i (
    .clk(wrClk), .rstN(rstN), .d(takeTgl), .q(ackSync)
  );

  xdom_mbox_sync #(.Stages(SyncStages)) postSync_i (
    .clk(rdClk), .rstN(rstN), .d(postTgl), .q(postSync)
  );

  assign pending  = postSync != takeTgl;
  assign acceptRd = rdEn && rdMbSel && pending;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         takeTgl <= 1'b0;
    else if (acceptRd) takeTgl <= ~takeTgl;
  end

  assign fifoWrEn         = wrEn && !wrMbSel;
  assign fifoRdEn         = rdEn && !rdMbSel;
  assign mbFullN          = ~holdFull;
  assign strobes.loadWord = acceptWr;
  assign strobes.showMbox = rdMbSel;
endmodule

// File: rtl/xdom_mbox_dpath.sv
module xdom_mbox_dpath
  import xdom_mailbox_pkg::*;
#(
  parameter int Width = 36
) (
  input  logic             wrClk,
  input  logic             mstRstN,
  input  mbStrobes_t       strobes,
  input  logic [Width-1:0] wrData,
  input  logic [Width-1:0] fifoRdData,
  output logic [Width-1:0] fifoWrData,
  output logic [Width-1:0] rdData,
  output logic [Width-1:0] mbWord
);
  // only the master reset clears the word; a partial reset keeps it
  always_ff @(posedge wrClk or negedge mstRstN) begin
    if (!mstRstN)              mbWord <= '0;
    else if (strobes.loadWord) mbWord <= wrData;
  end

  assign fifoWrData = wrData;
  assign rdData     = strobes.showMbox ? mbWord : fifoRdData;
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import xdom_mailbox_pkg::*;
#(
  parameter int Width      = 36,
  parameter int SyncStages = 2
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mstRstN,
  input  logic             prtRstN,
  input  logic             wrEn,
  input  logic             wrMbSel,
  input  logic [Width-1:0] wrData,
  output logic             fifoWrEn,
  output logic [Width-1:0] fifoWrData,
  output logic             mbFullN,
  input  logic             rdEn,
  input  logic             rdMbSel,
  input  logic [Width-1:0] fifoRdData,
  output logic             fifoRdEn,
  output logic [Width-1:0] rdData
);
  logic             rstN;
  mbStrobes_t       strobes;
  logic [Width-1:0] mbWord;

  assign rstN = mstRstN && prtRstN;

  xdom_mbox_ctrl #(.SyncStages(SyncStages)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrMbSel(wrMbSel), .rdEn(rdEn), .rdMbSel(rdMbSel),
    .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn), .mbFullN(mbFullN),
    .strobes(strobes)
  );

  xdom_mbox_dpath #(.Width(Width)) dpath_i (
    .wrClk(wrClk), .mstRstN(mstRstN), .strobes(strobes),
    .wrData(wrData), .fifoRdData(fifoRdData),
    .fifoWrData(fifoWrData), .rdData(rdData), .mbWord(mbWord)
  );
endmodule

// File: rtl/xdom_mailbox_chk.sv
module xdom_mailbox_chk #(
  parameter int Width = 36
) (
  input logic             wrClk,
  input logic             mstRstN,
  input logic             prtRstN,
  input logic             wrEn,
  input logic             wrMbSel,
  input logic             mbFullN,
  input logic [Width-1:0] mbWord
);
  // R2: an accepted mailbox write empties the flag on the next cycle
  assert_full_after_write_R2: assert property (
    @(posedge wrClk) disable iff (!mstRstN || !prtRstN)
    (wrEn && wrMbSel && mbFullN) |=> !mbFullN);

  // R3: while the flag stays low, the stored word does not move
  assert_word_held_R3: assert property (
    @(posedge wrClk) disable iff (!mstRstN || !prtRstN)
    !mbFullN |=> (mbFullN || $stable(mbWord)));

  // R6: a FIFO-routed write never fills an empty mailbox
  assert_fifo_write_bypass_R6: assert property (
    @(posedge wrClk) disable iff (!mstRstN || !prtRstN)
    (wrEn && !wrMbSel && mbFullN) |=> mbFullN);

  // R1 and R9: during master reset the flag is high and the word is zero
  always @(posedge wrClk) begin
    if (!mstRstN) begin
      assert_master_reset_R9: assert (mbFullN && mbWord == '0);
    end
  end

  // R8: during partial reset the flag is high
  always @(posedge wrClk) begin
    if (mstRstN && !prtRstN) begin
      assert_partial_reset_R8: assert (mbFullN);
    end
  end
endmodule

bind xdom_mailbox xdom_mailbox_chk #(.Width(Width)) chk_i (
  .wrClk(wrClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
  .wrEn(wrEn), .wrMbSel(wrMbSel), .mbFullN(mbFullN), .mbWord(mbWord)
);

// File: tb/xdom_mailbox_tb_top.sv
`timescale 1ns/1ps
module xdom_mailbox_tb_top;
  localparam int W = 36;

  logic          wrClk = 1'b0;
  logic          rdClk = 1'b0;
  logic          mstRstN = 1'b1;
  logic          prtRstN = 1'b1;
  logic          wrEn = 1'b0;
  logic          wrMbSel = 1'b0;
  logic [W-1:0]  wrData = '0;
  logic          fifoWrEn;
  logic [W-1:0]  fifoWrData;
  logic          mbFullN;
  logic          rdEn = 1'b0;
  logic          rdMbSel = 1'b0;
  logic [W-1:0]  fifoRdData = '0;
  logic          fifoRdEn;
  logic [W-1:0]  rdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 wrClk = ~wrClk;   // 50 MHz
  always #17 rdClk = ~rdClk;

  xdom_mailbox #(.Width(W)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .prtRstN(prtRstN),
    .wrEn(wrEn), .wrMbSel(wrMbSel), .wrData(wrData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .mbFullN(mbFullN),
    .rdEn(rdEn), .rdMbSel(rdMbSel), .fifoRdData(fifoRdData),
    .fifoRdEn(fifoRdEn), .rdData(rdData)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peekWord(input string req, input logic [W-1:0] exp);
    @(negedge rdClk);
    rdMbSel = 1'b1;
    #1 check(req, rdData, exp);
  endtask

  task automatic mbWrite(input logic [W-1:0] d);
    @(negedge wrClk);
    wrEn = 1'b1; wrMbSel = 1'b1; wrData = d;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic mbRead();
    @(negedge rdClk);
    rdEn = 1'b1; rdMbSel = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic waitWr(input int n);
    for (int i = 0; i < n; i++) @(negedge wrClk);
  endtask

  task automatic doMasterReset();
    @(negedge wrClk);
    mstRstN = 1'b0;
    waitWr(3);
    check("R1", {35'd0, mbFullN}, 36'd1);
    mstRstN = 1'b1;
    waitWr(2);
  endtask

  task automatic testReset();
    mstRstN = 1'b0;
    waitWr(4);
    mstRstN = 1'b1;
    waitWr(2);
    check("R1", {35'd0, mbFullN}, 36'd1);
    peekWord("R1", '0);
  endtask

  task automatic testPostAndTake();
    logic [W-1:0] d = 36'h9_1234_5678;
    @(negedge wrClk);
    wrEn = 1'b1; wrMbSel = 1'b1; wrData = d;
    #1 check("R2", {35'd0, mbFullN}, 36'd1);
    @(negedge wrClk);
    wrEn = 1'b0;
    check("R2", {35'd0, mbFullN}, 36'd0);
    peekWord("R5", d);
    fifoRdData = 36'hA_5A5A_5A5A;
    @(negedge rdClk);
    rdMbSel = 1'b0;
    #1 check("R5", rdData, 36'hA_5A5A_5A5A);
    waitWr(4);
    mbRead();
    waitWr(4);
    check("R4", {35'd0, mbFullN}, 36'd1);
  endtask

  task automatic testIgnoreWhenFull();
    mbWrite(36'h1_1111_1111);
    mbWrite(36'h2_2222_2222);
    check("R3", {35'd0, mbFullN}, 36'd0);
    peekWord("R3", 36'h1_1111_1111);
    waitWr(4);
    mbRead();
    waitWr(5);
    check("R3", {35'd0, mbFullN}, 36'd1);
  endtask

  task automatic testFifoRouting();
    @(negedge wrClk);
    wrEn = 1'b1; wrMbSel = 1'b0; wrData = 36'h3_CAFE_0001;
    #1 check("R6", {35'd0, fifoWrEn}, 36'd1);
    check("R6", fifoWrData, 36'h3_CAFE_0001);
    @(negedge wrClk);
    wrEn = 1'b0;
    check("R6", {35'd0, mbFullN}, 36'd1);
    peekWord("R6", 36'h1_1111_1111);
    mbWrite(36'h4_0000_00FF);
    waitWr(4);
    @(negedge rdClk);
    rdEn = 1'b1; rdMbSel = 1'b0;
    #1 check("R7", {35'd0, fifoRdEn}, 36'd1);
    @(negedge rdClk);
    rdEn = 1'b0;
    waitWr(6);
    check("R7", {35'd0, mbFullN}, 36'd0);
    mbRead();
    waitWr(5);
    check("R4", {35'd0, mbFullN}, 36'd1);
  endtask

  task automatic testPartialReset();
    mbWrite(36'h5_DEAD_BEEF);
    check("R8", {35'd0, mbFullN}, 36'd0);
    @(negedge wrClk);
    prtRstN = 1'b0;
    waitWr(2);
    prtRstN = 1'b1;
    waitWr(2);
    check("R8", {35'd0, mbFullN}, 36'd1);
    peekWord("R8", 36'h5_DEAD_BEEF);
  endtask

  task automatic testMasterReset();
    mbWrite(36'h6_0BAD_F00D);
    doMasterReset();
    check("R9", {35'd0, mbFullN}, 36'd1);
    peekWord("R9", '0);
  endtask

  task automatic testEmptyRead();
    mbRead();
    waitWr(6);
    mbWrite(36'h7_7777_0000);
    waitWr(10);
    check("R10", {35'd0, mbFullN}, 36'd0);
    mbRead();
    waitWr(5);
    check("R10", {35'd0, mbFullN}, 36'd1);
  endtask

  // write attempt in the cycle the acknowledge lands
  task automatic testCollision();
    logic [W-1:0] exp = '0;
    bit got = 0;
    mbWrite(36'h8_0000_0A00);
    waitWr(4);
    mbRead();
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrMbSel = 1'b1; wrData = 36'h8_0000_1000 + i;
      if (mbFullN) begin
        exp = wrData;
        got = 1;
      end
    end
    @(negedge wrClk);
    wrEn = 1'b0;
    check("R4", {35'd0, got}, 36'd1);
    check("R2", {35'd0, mbFullN}, 36'd0);
    peekWord("R3", exp);
    waitWr(4);
    mbRead();
    waitWr(5);
  endtask

  initial begin
    testReset();
    testPostAndTake();
    testIgnoreWhenFull();
    testFifoRouting();
    testPartialReset();
    testMasterReset();
    testEmptyRead();
    testCollision();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule